// File: doc/BRIEF.md
# Rank Idle Power-Down Controller

This block sits beside the command path of a DRAM memory controller and decides, rank by rank, when a rank may enter a low-power state and when it must be woken again. It observes two event streams: commands leaving the memory queue towards the DRAM (the issue stream), and commands entering that queue from the scheduler (the enqueue stream). It also sees a snapshot of every queue slot: its valid bit and the rank it addresses. Each rank has a small idle countdown and a low-power flag.

An issued command reloads the countdown of its own rank. It also ticks every other rank's countdown one step closer to zero. A rank is put to sleep only when its countdown is exhausted, it is not already asleep, and no waiting queue entry targets it. This look-ahead stops a power-down just before an access to that rank reaches the head of the queue. A command entering the queue for a sleeping rank raises a wake request at once, well before that command can issue.

Both event streams are observation-only strobes with no ready signal. The block never applies back-pressure, and every strobe is taken in the cycle it is presented. The request outputs are plain per-rank pulses for the DRAM command sequencer.

Top module: `rank_pd_ctrl`

## Requirements
- R1: After reset, all request outputs and all low-power flags are 0, and every rank's countdown holds 8. No power-down can happen until 8 commands to other ranks have issued.
- R2: An issued command to rank r (`iss_valid`=1, `iss_rank`=r) reloads rank r's countdown to 8.
- R3: An issued command lowers the countdown of every rank other than its target by one. The countdown stops at 0 and never wraps. A cycle with no issue and no enqueue leaves every countdown unchanged.
- R4: `pd_req[r]` is a one-cycle pulse. It is high in the cycle after a clock edge at which all of these held: rank r's countdown was 0, `low_power[r]` was 0, no valid queue entry targeted r, and no enqueue targeted r.
- R5: The clock edge that raises `pd_req[r]` also sets `low_power[r]`. While `low_power[r]` is set, no further `pd_req[r]` is issued.
- R6: Queue entry e addresses the rank in bits `q_rank[e*RW +: RW]` and counts only while `q_valid[e]` is 1. An entry with `q_valid[e]`=0 never holds off a power-down, even if its rank field matches.
- R7: An enqueue for rank r (`enq_valid`=1, `enq_rank`=r) reloads rank r's countdown to 8. If `low_power[r]` was set, `pu_req[r]` pulses for one cycle after that edge, and `low_power[r]` clears at the same edge.
- R8: An enqueue for rank r in the same cycle as a pending power-down condition for r suppresses that power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A command leaves the memory queue towards DRAM this cycle |
| iss_rank | input | RW | Rank of the issued command |
| enq_valid | input | 1 | A command enters the memory queue this cycle |
| enq_rank | input | RW | Rank of the entering command |
| q_valid | input | QDEPTH | Per-slot valid bits of the memory queue |
| q_rank | input | QDEPTH*RW | Per-slot rank fields, slot e in bits e*RW +: RW |
| pd_req | output | NRANKS | One-cycle power-down request per rank |
| pu_req | output | NRANKS | One-cycle power-up request per rank |
| low_power | output | NRANKS | Rank currently held in low power |

## Verification
The embedded properties rely on several promises about the inputs:
- `iss_rank` and `enq_rank` name an existing rank whenever their strobe is high.
- No command issues to a rank that is still flagged low-power, because a wake always precedes its issue through the queue.
- At most one command issues per cycle.

The directed stimulus keeps to these promises. It only issues to rank 0, which is never put to sleep, and it wakes other ranks solely through the enqueue strobe. All strobes are driven on the falling edge and held for exactly one cycle.

// File: rtl/rank_pd_pkg.sv
package rank_pd_pkg;
  localparam int unsigned DEF_NRANKS = 4;
  localparam int unsigned DEF_QDEPTH = 8;
  localparam int unsigned DEF_RELOAD = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rank_pd_lookahead.sv
module rank_pd_lookahead #(
  parameter int unsigned NRANKS = rank_pd_pkg::DEF_NRANKS,
  parameter int unsigned QDEPTH = rank_pd_pkg::DEF_QDEPTH,
  parameter int unsigned RW     = rank_pd_pkg::idx_width(NRANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [QDEPTH-1:0]    q_valid,
  input  logic [QDEPTH*RW-1:0] q_rank,
  output logic [NRANKS-1:0]    pending
);
  // a rank is pending when any valid slot names it
  for (genvar r = 0; r < NRANKS; r++) begin : g_rank
    always_comb begin
      pending[r] = 1'b0;
      for (int e = 0; e < QDEPTH; e++) begin
        if (q_valid[e] && (q_rank[e*RW +: RW] == RW'(r)))
          pending[r] = 1'b1;
      end
    end

    for (genvar e = 0; e < QDEPTH; e++) begin : g_slot
      // R6: a valid matching slot must be seen as pending
      a_r6_slot_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid[e] && (q_rank[e*RW +: RW] == RW'(r))) |-> pending[r]);
    end
  end
endmodule

// File: rtl/rank_pd_slot.sv
module rank_pd_slot #(
  parameter int unsigned RELOAD = rank_pd_pkg::DEF_RELOAD,
  parameter int unsigned CW     = $clog2(RELOAD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_any,
  input  logic issue_hit,
  input  logic wake_hit,
  input  logic pending,
  output logic pd_req,
  output logic pu_req,
  output logic low_power
);
  localparam logic [CW-1:0] LOAD_VAL = CW'(RELOAD);

  logic [CW-1:0] cnt_q;
  logic          lp_q, pd_q, pu_q;
  logic          cnt_zero, pd_go;

  assign cnt_zero = (cnt_q == '0);
  assign pd_go    = cnt_zero && !lp_q && !pending && !wake_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= LOAD_VAL;
      lp_q  <= 1'b0;
      pd_q  <= 1'b0;
      pu_q  <= 1'b0;
    end else begin
      pd_q <= pd_go;
      pu_q <= wake_hit && lp_q;
      if (issue_hit || wake_hit)
        cnt_q <= LOAD_VAL;
      else if (issue_any && !cnt_zero)
        cnt_q <= cnt_q - 1'b1;
      if (wake_hit)
        lp_q <= 1'b0;
      else if (pd_go)
        lp_q <= 1'b1;
    end
  end

  assign pd_req    = pd_q;
  assign pu_req    = pu_q;
  assign low_power = lp_q;

  a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_hit || wake_hit) |=> (cnt_q == LOAD_VAL));
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_any && !issue_hit && !wake_hit && !cnt_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && !issue_hit && !wake_hit) |=> cnt_zero);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_any && !wake_hit) |=> $stable(cnt_q));
  a_r4_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |=> !pd_q);
  a_r4_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> $past(cnt_zero && !pending && !lp_q));
  a_r5_mark: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> lp_q);
  a_r7_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit && lp_q) |=> (pu_q && !lp_q));
  a_r8_block: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |=> !pd_q);
endmodule

// File: rtl/rank_pd_ctrl.sv
module rank_pd_ctrl #(
  parameter int unsigned NRANKS = rank_pd_pkg::DEF_NRANKS,
  parameter int unsigned QDEPTH = rank_pd_pkg::DEF_QDEPTH,
  parameter int unsigned RELOAD = rank_pd_pkg::DEF_RELOAD,
  localparam int unsigned RW    = rank_pd_pkg::idx_width(NRANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iss_valid,
  input  logic [RW-1:0]        iss_rank,
  input  logic                 enq_valid,
  input  logic [RW-1:0]        enq_rank,
  input  logic [QDEPTH-1:0]    q_valid,
  input  logic [QDEPTH*RW-1:0] q_rank,
  output logic [NRANKS-1:0]    pd_req,
  output logic [NRANKS-1:0]    pu_req,
  output logic [NRANKS-1:0]    low_power
);
  logic [NRANKS-1:0] pending;

  rank_pd_lookahead #(.NRANKS(NRANKS), .QDEPTH(QDEPTH), .RW(RW)) u_look (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_rank(q_rank), .pending(pending)
  );

  for (genvar r = 0; r < NRANKS; r++) begin : g_slot
    logic issue_hit, wake_hit;
    assign issue_hit = iss_valid && (iss_rank == RW'(r));
    assign wake_hit  = enq_valid && (enq_rank == RW'(r));

    rank_pd_slot #(.RELOAD(RELOAD)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .issue_any(iss_valid), .issue_hit(issue_hit), .wake_hit(wake_hit),
      .pending(pending[r]),
      .pd_req(pd_req[r]), .pu_req(pu_req[r]), .low_power(low_power[r])
    );

    // R7: wake and sleep requests for one rank never coincide
    a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(pd_req[r] && pu_req[r]));
  end

  // R2: issued rank must exist (input promise)
  a_r2_rank_range: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (int'(iss_rank) < int'(NRANKS)));
  // R7: enqueued rank must exist (input promise)
  a_r7_rank_range: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid |-> (int'(enq_rank) < int'(NRANKS)));
endmodule

// File: tb/rank_pd_ctrl_test.sv
`timescale 1ns/1ps
module rank_pd_ctrl_test;
  localparam int NR = 4;
  localparam int QD = 8;
  localparam int RW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [RW-1:0] iss_rank = '0;
  logic enq_valid = 1'b0;
  logic [RW-1:0] enq_rank = '0;
  logic [QD-1:0] q_valid = '0;
  logic [QD*RW-1:0] q_rank = '0;
  logic [NR-1:0] pd_req, pu_req, low_power;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rank_pd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_rank(iss_rank),
    .enq_valid(enq_valid), .enq_rank(enq_rank), .q_valid(q_valid), .q_rank(q_rank),
    .pd_req(pd_req), .pu_req(pu_req), .low_power(low_power)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [NR-1:0] act, input logic [NR-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic issue(input int r);
    iss_valid = 1'b1;
    iss_rank  = RW'(r);
    step();
    iss_valid = 1'b0;
  endtask

  task automatic enqueue(input int r);
    enq_valid = 1'b1;
    enq_rank  = RW'(r);
    step();
    enq_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 pd after reset", pd_req, 4'b0000);
    chk("R1 pu after reset", pu_req, 4'b0000);
    chk("R1 low_power after reset", low_power, 4'b0000);
    repeat (10) step();
    chk("R1 no pd while idle after reset", pd_req | low_power, 4'b0000);
  endtask

  task automatic t_countdown();
    for (int i = 0; i < 7; i++) issue(0);
    repeat (4) step();
    chk("R3 counters hold without issue", pd_req | low_power, 4'b0000);
    issue(0);
    chk("R4 pd registered one cycle later", pd_req, 4'b0000);
    step();
    chk("R4 pd fires on exhausted ranks", pd_req, 4'b1110);
    chk("R5 low_power set with pd", low_power, 4'b1110);
    step();
    chk("R4 pd is single pulse", pd_req, 4'b0000);
    repeat (3) step();
    chk("R5 no repeat pd while asleep", pd_req, 4'b0000);
    chk("R5 flags stay set", low_power, 4'b1110);
  endtask

  task automatic t_wake();
    enqueue(2);
    chk("R7 pu pulse for sleeping rank", pu_req, 4'b0100);
    chk("R7 flag cleared on wake", low_power, 4'b1010);
    step();
    chk("R7 pu single pulse", pu_req, 4'b0000);
    for (int i = 0; i < 7; i++) issue(0);
    chk("R2 woken rank counter reloaded to 8", pd_req, 4'b0000);
    issue(0);
    step();
    chk("R2 pd after 8 foreign issues", pd_req, 4'b0100);
    chk("R5 flags after second sleep", low_power, 4'b1110);
  endtask

  task automatic t_lookahead();
    q_rank[0*RW +: RW] = 2'd3;
    q_valid[0] = 1'b1;
    q_rank[1*RW +: RW] = 2'd3;
    q_valid[1] = 1'b0;
    enqueue(3);
    chk("R7 pu for rank 3", pu_req, 4'b1000);
    for (int i = 0; i < 20; i++) issue(0);
    repeat (2) step();
    chk("R6 valid queue entry holds off pd", pd_req, 4'b0000);
    chk("R6 rank 3 stays awake", low_power, 4'b0110);
    q_valid[0] = 1'b0;
    step();
    chk("R6 invalid entry ignored, R3 counter saturated at 0", pd_req, 4'b1000);
    chk("R5 rank 3 flagged", low_power, 4'b1110);
  endtask

  task automatic t_enq_block();
    enqueue(1);
    chk("R7 pu for rank 1", pu_req, 4'b0010);
    chk("R7 rank 1 awake", low_power, 4'b1100);
    for (int i = 0; i < 8; i++) issue(0);
    enqueue(1);
    chk("R8 enqueue suppresses pd", pd_req, 4'b0000);
    chk("R7 no pu for awake rank", pu_req, 4'b0000);
    repeat (3) step();
    chk("R8 still no pd after reload", pd_req | (low_power & 4'b0010), 4'b0000);
    for (int i = 0; i < 7; i++) issue(0);
    chk("R7 enqueue reloaded counter to 8", pd_req, 4'b0000);
    issue(0);
    step();
    chk("R7 pd after reloaded countdown", pd_req, 4'b0010);
    chk("R5 all idle ranks asleep", low_power, 4'b1110);
  endtask

  initial begin
    repeat (5) step();
    rst_n = 1'b1;
    step();
    t_reset_state();
    t_countdown();
    t_wake();
    t_lookahead();
    t_enq_block();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule